// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It does so by reading two levels of translation entries from memory. The upper ten address bits pick an entry in a directory whose base comes from `dir_base`. That entry names the frame of a second-level table. The next ten bits pick an entry in that table, and that entry names the frame of the 4 KiB page. The low twelve bits pass through as the offset. During the walk the block keeps the usage flags in memory up to date. It sets the accessed flag in both entries it uses, and on a write request it also sets the dirty flag in the second-level entry. It writes an entry back only when one of those flags actually changes.

A client raises `req_valid` with `req_laddr` and `req_write` while `busy` is low. The block then holds `busy` high until it returns a one-cycle `done` pulse. The pulse carries `fault` and `paddr`. When `pg_en` is low at acceptance, the walk is skipped and the linear address is returned unchanged, with no memory traffic. Memory is reached through a request/ready port. A request stays stable until `mem_ready` is high at a clock edge, and read data is taken in that same cycle.

The controller has six states. `S_IDLE` waits for a request. On acceptance it goes to `S_DIR_RD` when paging is enabled, or to `S_FINISH` when paging is off. `S_DIR_RD` reads the directory entry. From there it goes to `S_FINISH` if the entry is not present, to `S_DIR_WR` if the accessed flag must be set, and to `S_TBL_RD` otherwise. `S_DIR_WR` writes the directory entry back and then goes to `S_TBL_RD`. `S_TBL_RD` reads the table entry. From there it goes to `S_FINISH` if the entry is not present or needs no update, and to `S_TBL_WR` if it does. `S_TBL_WR` writes the table entry back and goes to `S_FINISH`. `S_FINISH` raises `done` and returns to `S_IDLE`.

Top module: `pt_walker`

## Requirements
- R1: With paging enabled and both entries present, `paddr` equals bits 31:12 of the second-level entry followed by `req_laddr[11:0]`. The directory entry is read at `dir_base + req_laddr[31:22]*4`, and the table entry at `{dir_entry[31:12],12'h000} + req_laddr[21:12]*4`.
- R2: If the directory entry has bit 0 (present) equal to 0, the request ends with `fault`=1 and `paddr`=0. No table entry is read and nothing is written.
- R3: If the second-level entry has bit 0 equal to 0, the request ends with `fault`=1 and `paddr`=0, and that entry is not written.
- R4: Before `done`, bit 5 (accessed) is 1 in memory for both the directory entry and the table entry of a successful walk. This holds for reads and for writes.
- R5: Bit 6 (dirty) of the second-level entry is set to 1 only by write requests. Bit 6 of a directory entry is never changed.
- R6: When `pg_en` is 0 at acceptance, `paddr` equals `req_laddr`, `fault` is 0, and no memory request is made.
- R7: An entry is written back only if its accessed or dirty bit changes. A write-back keeps every other bit of the entry unchanged.
- R8: `busy` is high from the cycle after acceptance until `done`. `done` lasts exactly one cycle. A `req_valid` raised while `busy` is high is ignored.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_en | input | 1 | Paging enable, sampled on acceptance |
| dir_base | input | 32 | Directory base address, low 12 bits zero |
| req_valid | input | 1 | Translation request |
| req_write | input | 1 | Request is for a write access |
| req_laddr | input | 32 | Linear address |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Not-present fault, valid with `done` |
| paddr | output | 32 | Physical address, valid with `done` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the access this cycle |

## Verification
The hardest case to reach is the one where flag write-backs are skipped. A walk goes straight from `S_DIR_RD` to `S_TBL_RD`, or from `S_TBL_RD` to `S_FINISH`, only when earlier requests have already set the flags in memory. The vector table is therefore ordered so that the same page is first read, then read again, and then written. Together with entries preloaded with accessed or dirty already set, this makes the number of write-backs differ from vector to vector. The bench memory also stalls `mem_ready` on a repeating pattern, so that every request has to be held across wait cycles.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam int ADDR_W  = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int PRES_B  = 0;
    localparam int ACC_B   = 5;
    localparam int DIRTY_B = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_RD,
        S_DIR_WR,
        S_TBL_RD,
        S_TBL_WR,
        S_FINISH
    } walk_state_e;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int AW    = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] laddr_i,
    input  logic [AW-1:0] dir_ent_i,
    output logic [AW-1:0] dir_addr_o,
    output logic [AW-1:0] tbl_addr_o
);
    localparam int FRAME_W = AW - OFF_W;
    localparam int PAD_W   = AW - IDX_W - 2;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;
    logic [AW-1:0]    tbl_base;

    assign dir_idx  = laddr_i[AW-1 -: IDX_W];
    assign tbl_idx  = laddr_i[OFF_W +: IDX_W];
    assign tbl_base = {dir_ent_i[AW-1 -: FRAME_W], {OFF_W{1'b0}}};

    assign dir_addr_o = base_i   + {{PAD_W{1'b0}}, dir_idx, 2'b00};
    assign tbl_addr_o = tbl_base + {{PAD_W{1'b0}}, tbl_idx, 2'b00};
endmodule

// File: rtl/pt_entry_upd.sv
module pt_entry_upd #(
    parameter int W       = 32,
    parameter int ACC_B   = 5,
    parameter int DIRTY_B = 6
) (
    input  logic [W-1:0] ent_i,
    input  logic         set_dirty_i,
    output logic [W-1:0] ent_o,
    output logic         changed_o
);
    always_comb begin
        ent_o        = ent_i;
        ent_o[ACC_B] = 1'b1;
        if (set_dirty_i) begin
            ent_o[DIRTY_B] = 1'b1;
        end
    end

    assign changed_o = (ent_o != ent_i);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_pkg::*;
#(
    parameter int AW = pt_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pg_en,
    input  logic [AW-1:0] dir_base,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_laddr,
    output logic          busy,
    output logic          done,
    output logic          fault,
    output logic [AW-1:0] paddr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_ready
);
    localparam int FRAME_W = AW - OFF_W;

    walk_state_e state_q, state_d;

    logic [AW-1:0] laddr_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] dir_ent_q;
    logic [AW-1:0] tbl_ent_q;
    logic          wr_q;
    logic          pg_q;
    logic          fault_q;

    logic [AW-1:0] dir_addr, tbl_addr;
    logic [AW-1:0] dir_upd_in, tbl_upd_in;
    logic [AW-1:0] dir_upd_ent, tbl_upd_ent;
    logic          dir_chg, tbl_chg;
    logic          accept;

    assign accept = (state_q == S_IDLE) && req_valid;

    pt_addr_gen #(
        .AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)
    ) u_addr (
        .base_i    (base_q),
        .laddr_i   (laddr_q),
        .dir_ent_i (dir_ent_q),
        .dir_addr_o(dir_addr),
        .tbl_addr_o(tbl_addr)
    );

    assign dir_upd_in = (state_q == S_DIR_RD) ? mem_rdata : dir_ent_q;
    assign tbl_upd_in = (state_q == S_TBL_RD) ? mem_rdata : tbl_ent_q;

    pt_entry_upd #(
        .W(AW), .ACC_B(ACC_B), .DIRTY_B(DIRTY_B)
    ) u_dir_upd (
        .ent_i      (dir_upd_in),
        .set_dirty_i(1'b0),
        .ent_o      (dir_upd_ent),
        .changed_o  (dir_chg)
    );

    pt_entry_upd #(
        .W(AW), .ACC_B(ACC_B), .DIRTY_B(DIRTY_B)
    ) u_tbl_upd (
        .ent_i      (tbl_upd_in),
        .set_dirty_i(wr_q),
        .ent_o      (tbl_upd_ent),
        .changed_o  (tbl_chg)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) state_d = pg_en ? S_DIR_RD : S_FINISH;
            end
            S_DIR_RD: begin
                if (mem_ready) begin
                    if (!mem_rdata[PRES_B]) state_d = S_FINISH;
                    else if (dir_chg)       state_d = S_DIR_WR;
                    else                    state_d = S_TBL_RD;
                end
            end
            S_DIR_WR: begin
                if (mem_ready) state_d = S_TBL_RD;
            end
            S_TBL_RD: begin
                if (mem_ready) begin
                    if (!mem_rdata[PRES_B]) state_d = S_FINISH;
                    else if (tbl_chg)       state_d = S_TBL_WR;
                    else                    state_d = S_FINISH;
                end
            end
            S_TBL_WR: begin
                if (mem_ready) state_d = S_FINISH;
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State and walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            laddr_q   <= '0;
            base_q    <= '0;
            dir_ent_q <= '0;
            tbl_ent_q <= '0;
            wr_q      <= 1'b0;
            pg_q      <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                laddr_q <= req_laddr;
                base_q  <= dir_base;
                wr_q    <= req_write;
                pg_q    <= pg_en;
                fault_q <= 1'b0;
            end
            if (state_q == S_DIR_RD && mem_ready) begin
                dir_ent_q <= mem_rdata;
                if (!mem_rdata[PRES_B]) fault_q <= 1'b1;
            end
            if (state_q == S_TBL_RD && mem_ready) begin
                tbl_ent_q <= mem_rdata;
                if (!mem_rdata[PRES_B]) fault_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            S_DIR_RD: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
            end
            S_DIR_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_addr;
                mem_wdata = dir_upd_ent;
            end
            S_TBL_RD: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
            end
            S_TBL_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_addr;
                mem_wdata = tbl_upd_ent;
            end
            default: ;
        endcase
        busy  = (state_q != S_IDLE);
        done  = (state_q == S_FINISH);
        fault = fault_q;
        if (fault_q)   paddr = '0;
        else if (pg_q) paddr = {tbl_ent_q[AW-1 -: FRAME_W], laddr_q[OFF_W-1:0]};
        else           paddr = laddr_q;
    end

    // Assertions
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (busy && !pg_q) |-> !mem_req); // R6
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && fault) |-> (paddr == '0)); // R2
    AST_WB_ACC: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we) |-> mem_wdata[ACC_B]); // R4
    AST_DIR_DIRTY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DIR_WR) |-> (mem_wdata[DIRTY_B] == dir_ent_q[DIRTY_B])); // R5
    AST_WB_FRAME_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TBL_WR) |-> (mem_wdata[AW-1:OFF_W] == tbl_ent_q[AW-1:OFF_W])); // R7
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy); // R8
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    localparam time CLK_PER = 10ns;

    typedef struct packed {
        logic        pg;
        logic        wr;
        logic [31:0] la;
        logic        flt;
        logic [31:0] pa;
        logic [1:0]  nrd;
        logic [1:0]  nwr;
    } vec_t;

    // Ordered: flag state in memory carries from one vector to the next
    localparam vec_t VECS [9] = '{
        '{1'b1, 1'b0, 32'h0040_5123, 1'b0, 32'h0050_0123, 2'd2, 2'd2},
        '{1'b1, 1'b0, 32'h0040_5ABC, 1'b0, 32'h0050_0ABC, 2'd2, 2'd0},
        '{1'b1, 1'b1, 32'h0040_5004, 1'b0, 32'h0050_0004, 2'd2, 2'd1},
        '{1'b1, 1'b1, 32'h0040_6FFF, 1'b0, 32'h0060_0FFF, 2'd2, 2'd1},
        '{1'b1, 1'b1, 32'h0080_7000, 1'b0, 32'h0070_0000, 2'd2, 2'd1},
        '{1'b1, 1'b0, 32'h0080_8010, 1'b1, 32'h0000_0000, 2'd2, 2'd0},
        '{1'b1, 1'b1, 32'h00C0_1234, 1'b1, 32'h0000_0000, 2'd1, 2'd0},
        '{1'b0, 1'b1, 32'hDEAD_BEEF, 1'b0, 32'hDEAD_BEEF, 2'd0, 2'd0},
        '{1'b0, 1'b0, 32'h0040_5123, 1'b0, 32'h0040_5123, 2'd0, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_en = 1'b0;
    logic [31:0] dir_base = 32'h0001_0000;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_laddr = '0;
    logic        busy, done, fault;
    logic [31:0] paddr;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:255];
    logic [1:0]  tick = '0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    logic        got_fault;
    logic [31:0] got_paddr;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .dir_base(dir_base),
        .req_valid(req_valid), .req_write(req_write), .req_laddr(req_laddr),
        .busy(busy), .done(done), .fault(fault), .paddr(paddr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic logic [7:0] widx(logic [31:0] a);
        return {a[17:16], a[7:2]};
    endfunction

    // Memory with a repeating stall pattern
    assign mem_ready = mem_req && (tick != 2'd0);
    assign mem_rdata = mem[widx(mem_addr)];

    always @(posedge clk) begin
        tick <= tick + 2'd1;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                mem[widx(mem_addr)] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(logic pg, logic wr, logic [31:0] la, output logic ok);
        int wait_n;
        @(negedge clk);
        pg_en = pg; req_write = wr; req_laddr = la; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 1000) begin
            @(negedge clk);
            wait_n++;
        end
        ok = done;
        got_fault = fault;
        got_paddr = paddr;
        if (!ok) begin
            n_chk++; n_bad++;
            $display("FAIL R8: actual no done expected done");
        end
        @(negedge clk);
        chk("R8 done one cycle", {31'b0, done}, 32'd0);
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_bad++;
        $display("FAIL R8: watchdog actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic ok;
        int r0, w0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        mem[widx(32'h0001_0004)] = 32'h0002_0000 | 32'h1;
        mem[widx(32'h0001_0008)] = 32'h0003_0E63;
        mem[widx(32'h0001_000C)] = 32'h0004_0000;
        mem[widx(32'h0002_0014)] = 32'h0050_0007;
        mem[widx(32'h0002_0018)] = 32'h0060_0001;
        mem[widx(32'h0003_001C)] = 32'h0070_0021;
        mem[widx(32'h0003_0020)] = 32'h0080_0000;

        repeat (3) @(negedge clk);
        chk("R8 reset busy", {31'b0, busy}, 32'd0);
        chk("R8 reset done", {31'b0, done}, 32'd0);
        chk("R9 reset mem_req", {31'b0, mem_req}, 32'd0);
        rst_n = 1'b1;

        // Vector table
        for (int v = 0; v < 9; v++) begin
            string tag;
            if (!VECS[v].pg)                          tag = "R6";
            else if (VECS[v].flt && VECS[v].nrd == 1) tag = "R2";
            else if (VECS[v].flt)                     tag = "R3";
            else                                      tag = "R1/R7";
            r0 = rd_cnt; w0 = wr_cnt;
            run(VECS[v].pg, VECS[v].wr, VECS[v].la, ok);
            chk($sformatf("%s v%0d fault", tag, v), {31'b0, got_fault}, {31'b0, VECS[v].flt});
            chk($sformatf("%s v%0d paddr", tag, v), got_paddr, VECS[v].pa);
            chk($sformatf("%s v%0d reads", tag, v), rd_cnt - r0, {30'b0, VECS[v].nrd});
            chk($sformatf("%s v%0d writes", tag, v), wr_cnt - w0, {30'b0, VECS[v].nwr});
        end

        // Resulting table contents
        chk("R4 R5 dir1 accessed, dirty untouched", mem[widx(32'h0001_0004)], 32'h0002_0021);
        chk("R5 R7 dir2 unchanged", mem[widx(32'h0001_0008)], 32'h0003_0E63);
        chk("R2 dir3 not written", mem[widx(32'h0001_000C)], 32'h0004_0000);
        chk("R4 R5 tbl5 accessed+dirty", mem[widx(32'h0002_0014)], 32'h0050_0067);
        chk("R5 R7 tbl6 flags set, rest kept", mem[widx(32'h0002_0018)], 32'h0060_0061);
        chk("R5 tbl7 dirty on write", mem[widx(32'h0003_001C)], 32'h0070_0061);
        chk("R3 tbl8 not written", mem[widx(32'h0003_0020)], 32'h0080_0000);

        // Request while busy is ignored
        @(negedge clk);
        pg_en = 1'b1; req_write = 1'b0; req_laddr = 32'h0040_5010; req_valid = 1'b1;
        @(negedge clk);
        chk("R8 busy after accept", {31'b0, busy}, 32'd1);
        req_laddr = 32'h00C0_0000;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int wait_n = 0;
            while (!done && wait_n < 1000) begin
                @(negedge clk);
                wait_n++;
            end
        end
        chk("R8 first request result", paddr, 32'h0050_0010);
        chk("R8 first request fault", {31'b0, fault}, 32'd0);
        begin
            int extra = 0;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk("R8 no second done", extra, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule